// File: doc/BRIEF.md
# Peripheral Interrupt/DMA Request Controller

This block sits beside one peripheral and turns that peripheral's trigger events into service requests. A trigger latches a pending flag. Two software mask bits then decide what the pending flag drives: a request to a DMA engine, a request to a DMA engine together with an end-of-block interrupt, or nothing. When the DMA engine or interrupt controller acknowledges the request, the flag drops. Software can also raise or cancel the pending flag directly through the control register.

The block also holds a 3-bit priority level for the arbiter, a counter-pointer register and an address-pointer register that a DMA engine reads. The counter-pointer register carries a target flag (memory or register file). The address-pointer register carries a segment-select flag that applies only when the target is memory. When the outside transaction counter reaches zero, the DMA mask clears itself, except while swap mode is active. The DMA engine, arbitration between sources and address extension all live outside this block.

Top module: `periph_req_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all three registers to zero, so every readback, decoded field and request output reads 0.
- R2: A trigger sets the pending flag on the next clock edge, and an acknowledge clears it. When both arrive in the same cycle, the flag ends up set.
- R3: A write to the control register (select code 0) loads the pending flag from data bit 5. This write overrides a trigger or acknowledge in the same cycle.
- R4: The DMA request output is high exactly when the pending flag and the DMA mask (control bit 4) are both 1. The end-of-block interrupt output is high exactly when the pending flag, the DMA mask and the interrupt mask (control bit 3) are all 1.
- R5: With the DMA mask at 0, neither request output is asserted, whatever the pending flag and the interrupt mask hold. This includes the reserved combination of DMA mask 0 with interrupt mask 1.
- R6: In a cycle where the counter-zero input is high and swap mode is low, the DMA mask clears on the next edge. With swap mode high, the DMA mask holds. A control-register write in the same cycle overrides both cases.
- R7: The control register reads back with the pending flag at bit 5, the DMA mask at bit 4, the interrupt mask at bit 3 and the priority at bits 2:0, where 0 is the highest priority and 7 the lowest. Bits 7:6 always read 0, and the priority is also output on its own.
- R8: A write with select code 1 loads the counter-pointer register. Bits 7:1 drive the counter pointer output, and bit 0 drives the target flag, where 1 means register file and 0 means memory.
- R9: A write with select code 2 loads the address-pointer register. Bits 7:1 drive the address pointer output. The segment-select output equals address bit 0 when the target flag is 0, and reads 0 when the target is the register file.
- R10: A register changes only when write enable is high and the select code names that register. Select code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Peripheral trigger event |
| ack_i | input | 1 | Request acknowledge |
| cnt_zero_i | input | 1 | Transaction counter has reached zero |
| swap_i | input | 1 | Swap mode active, blocks the DMA mask self-clear |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 counter pointer, 2 address pointer, 3 none |
| wr_data_i | input | 8 | Register write data |
| ctrl_o | output | 8 | Control register readback |
| cptr_o | output | 8 | Counter-pointer register readback |
| aptr_o | output | 8 | Address-pointer register readback |
| prio_o | output | 3 | Priority level, 0 highest |
| cnt_ptr_o | output | 7 | Transaction counter pointer |
| to_regfile_o | output | 1 | Transfer target is the register file |
| addr_ptr_o | output | 7 | Address register pointer |
| seg_alt_o | output | 1 | Alternate segment register selected (memory target only) |
| dma_req_o | output | 1 | DMA request |
| eob_irq_o | output | 1 | End-of-block interrupt request |

## Verification
The bench sweeps every combination of starting pending flag, both masks, trigger, acknowledge, counter-zero and swap mode. Each step checks the routing table before and after the hardware event. This sweep separates the four mask combinations, the trigger-over-acknowledge order and the swap exemption. Targeted collisions then check that a software write beats a trigger, an acknowledge and the self-clear. A sweep of pointer values with both target settings checks that the segment select follows the address register only for a memory target, and that select code 3 and cross-register writes leave the other registers unchanged.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CPTR = 2'd1,
    SEL_APTR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic dma;
    logic irq;
  } route_t;

  // Routing of the pending flag under the two masks.
  function automatic route_t route_req(logic pend, logic dm, logic im);
    route_t r;
    r.dma = pend & dm;
    r.irq = pend & dm & im;
    return r;
  endfunction

  // Pending flag: software write, then trigger, then acknowledge.
  function automatic logic next_pend(logic cur, logic trig, logic ack,
                                     logic sw_wr, logic sw_val);
    logic n;
    if (sw_wr)     n = sw_val;
    else if (trig) n = 1'b1;
    else if (ack)  n = 1'b0;
    else           n = cur;
    return n;
  endfunction

  // DMA mask: software write, then self-clear at counter zero outside swap.
  function automatic logic next_dm(logic cur, logic cz, logic swap,
                                   logic sw_wr, logic sw_val);
    logic n;
    if (sw_wr)            n = sw_val;
    else if (cz && !swap) n = 1'b0;
    else                  n = cur;
    return n;
  endfunction

endpackage

// File: rtl/prc_pend_flag.sv
module prc_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic ack,
  input  logic sw_wr,
  input  logic sw_val,
  output logic pend_q
);
  import prc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= next_pend(pend_q, trig, ack, sw_wr, sw_val);
  end

endmodule

// File: rtl/prc_mask_fields.sv
module prc_mask_fields #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic              sw_dm,
  input  logic              sw_im,
  input  logic [PRIO_W-1:0] sw_prio,
  input  logic              cnt_zero,
  input  logic              swap,
  output logic              dm_q,
  output logic              im_q,
  output logic [PRIO_W-1:0] prio_q
);
  import prc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_q   <= 1'b0;
      im_q   <= 1'b0;
      prio_q <= '0;
    end else begin
      dm_q <= next_dm(dm_q, cnt_zero, swap, sw_wr, sw_dm);
      if (sw_wr) begin
        im_q   <= sw_im;
        prio_q <= sw_prio;
      end
    end
  end

endmodule

// File: rtl/prc_ptr_reg.sv
module prc_ptr_reg #(
  parameter int PTR_W = 7,
  localparam int REG_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] reg_q,
  output logic [PTR_W-1:0] ptr,
  output logic             flag
);

  always_ff @(posedge clk) begin
    if (rst)     reg_q <= '0;
    else if (wr) reg_q <= wdata;
  end

  assign ptr  = reg_q[REG_W-1:1];
  assign flag = reg_q[0];

endmodule

// File: rtl/periph_req_ctrl.sv
module periph_req_ctrl #(
  parameter int PTR_W  = 7,
  parameter int PRIO_W = 3,
  localparam int REG_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              ack_i,
  input  logic              cnt_zero_i,
  input  logic              swap_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  cptr_o,
  output logic [REG_W-1:0]  aptr_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [PTR_W-1:0]  cnt_ptr_o,
  output logic              to_regfile_o,
  output logic [PTR_W-1:0]  addr_ptr_o,
  output logic              seg_alt_o,
  output logic              dma_req_o,
  output logic              eob_irq_o
);
  import prc_pkg::*;

  localparam int IM_BIT   = PRIO_W;
  localparam int DM_BIT   = PRIO_W + 1;
  localparam int PEND_BIT = PRIO_W + 2;
  localparam int NPTR     = 2;

  // Named internal events, also used by the checker.
  logic              sw_ctrl_wr;
  logic [NPTR-1:0]   sw_ptr_wr;
  logic              pend_q;
  logic              dm_q;
  logic              im_q;
  logic [PRIO_W-1:0] prio_q;
  route_t            route;

  logic [REG_W-1:0]  ptr_reg [NPTR];
  logic [PTR_W-1:0]  ptr_val [NPTR];
  logic [NPTR-1:0]   ptr_flag;

  assign sw_ctrl_wr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);

  prc_pend_flag u_pend (
    .clk    (clk),
    .rst    (rst),
    .trig   (trig_i),
    .ack    (ack_i),
    .sw_wr  (sw_ctrl_wr),
    .sw_val (wr_data_i[PEND_BIT]),
    .pend_q (pend_q)
  );

  prc_mask_fields #(.PRIO_W(PRIO_W)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .sw_wr    (sw_ctrl_wr),
    .sw_dm    (wr_data_i[DM_BIT]),
    .sw_im    (wr_data_i[IM_BIT]),
    .sw_prio  (wr_data_i[PRIO_W-1:0]),
    .cnt_zero (cnt_zero_i),
    .swap     (swap_i),
    .dm_q     (dm_q),
    .im_q     (im_q),
    .prio_q   (prio_q)
  );

  // Index 0: counter pointer, index 1: address pointer.
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam reg_sel_e SEL = (g == 0) ? SEL_CPTR : SEL_APTR;
    assign sw_ptr_wr[g] = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL);
    prc_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
      .clk   (clk),
      .rst   (rst),
      .wr    (sw_ptr_wr[g]),
      .wdata (wr_data_i),
      .reg_q (ptr_reg[g]),
      .ptr   (ptr_val[g]),
      .flag  (ptr_flag[g])
    );
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[PEND_BIT] = pend_q;
    ctrl_o[DM_BIT]   = dm_q;
    ctrl_o[IM_BIT]   = im_q;
    ctrl_o[PRIO_W-1:0] = prio_q;
  end

  assign route        = route_req(pend_q, dm_q, im_q);
  assign dma_req_o    = route.dma;
  assign eob_irq_o    = route.irq;
  assign prio_o       = prio_q;
  assign cptr_o       = ptr_reg[0];
  assign aptr_o       = ptr_reg[1];
  assign cnt_ptr_o    = ptr_val[0];
  assign to_regfile_o = ptr_flag[0];
  assign addr_ptr_o   = ptr_val[1];
  assign seg_alt_o    = ptr_flag[1] & ~ptr_flag[0];

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int REG_W  = 8,
  parameter int PRIO_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             ack,
  input logic             cnt_zero,
  input logic             swap,
  input logic             ctrl_wr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] ctrl,
  input logic [REG_W-1:0] cptr,
  input logic [REG_W-1:0] aptr,
  input logic             dma_req,
  input logic             eob_irq,
  input logic             wr_en
);
  localparam int DM_BIT   = PRIO_W + 1;
  localparam int PEND_BIT = PRIO_W + 2;

  a_r2_trig_sets: assert property (@(posedge clk) disable iff (rst)
    (trig && !ctrl_wr) |=> ctrl[PEND_BIT]);

  a_r2_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !trig && !ctrl_wr) |=> !ctrl[PEND_BIT]);

  a_r3_sw_pend: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl[PEND_BIT] == $past(wdata[PEND_BIT])));

  a_r4_dma_needs_pend: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> ctrl[PEND_BIT]);

  a_r5_irq_needs_dma: assert property (@(posedge clk) disable iff (rst)
    eob_irq |-> dma_req);

  a_r5_no_req_unmasked: assert property (@(posedge clk) disable iff (rst)
    !ctrl[DM_BIT] |-> (!dma_req && !eob_irq));

  a_r6_dm_selfclear: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && !swap && !ctrl_wr) |=> !ctrl[DM_BIT]);

  a_r6_swap_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && swap && !ctrl_wr) |=> (ctrl[DM_BIT] == $past(ctrl[DM_BIT])));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl[REG_W-1:PEND_BIT+1] == '0);

  a_r10_no_write_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cptr) && $stable(aptr)));

endmodule

bind periph_req_ctrl prc_checker #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trig     (trig_i),
  .ack      (ack_i),
  .cnt_zero (cnt_zero_i),
  .swap     (swap_i),
  .ctrl_wr  (sw_ctrl_wr),
  .wdata    (wr_data_i),
  .ctrl     (ctrl_o),
  .cptr     (cptr_o),
  .aptr     (aptr_o),
  .dma_req  (dma_req_o),
  .eob_irq  (eob_irq_o),
  .wr_en    (wr_en_i)
);

// File: tb/sim_periph_req_ctrl.sv
`timescale 1ns/1ps
module sim_periph_req_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_i = 0, ack_i = 0, cnt_zero_i = 0, swap_i = 0;
  logic       wr_en_i = 0;
  logic [1:0] wr_sel_i = 2'd3;
  logic [7:0] wr_data_i = '0;
  logic [7:0] ctrl_o, cptr_o, aptr_o;
  logic [2:0] prio_o;
  logic [6:0] cnt_ptr_o, addr_ptr_o;
  logic       to_regfile_o, seg_alt_o, dma_req_o, eob_irq_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  periph_req_ctrl u0 (
    .clk(clk), .rst(rst), .trig_i(trig_i), .ack_i(ack_i),
    .cnt_zero_i(cnt_zero_i), .swap_i(swap_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ctrl_o(ctrl_o),
    .cptr_o(cptr_o), .aptr_o(aptr_o), .prio_o(prio_o),
    .cnt_ptr_o(cnt_ptr_o), .to_regfile_o(to_regfile_o),
    .addr_ptr_o(addr_ptr_o), .seg_alt_o(seg_alt_o),
    .dma_req_o(dma_req_o), .eob_irq_o(eob_irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // One clock edge; inputs then change 1 ns later, away from the edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    trig_i = 0; ack_i = 0; cnt_zero_i = 0; swap_i = 0; wr_en_i = 0; wr_sel_i = 2'd3;
  endtask

  task automatic write(input logic [1:0] sel, input logic [7:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    cyc();
    wr_en_i = 0; wr_sel_i = 2'd3;
  endtask

  function automatic logic [7:0] ctrl_word(logic p, logic dm, logic im, logic [2:0] pr);
    return {2'b00, p, dm, im, pr};
  endfunction

  task automatic check_routes(input logic p, input logic dm, input logic im, input string ctx);
    string req;
    req = dm ? "R4" : "R5";
    chk(req, {ctx, " dma"}, 32'(dma_req_o), 32'(p & dm));
    chk(req, {ctx, " irq"}, 32'(eob_irq_o), 32'(p & dm & im));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (2) cyc();
    rst = 1'b0;
    // R1: reset state
    chk("R1", "ctrl", 32'(ctrl_o), 0);
    chk("R1", "cptr", 32'(cptr_o), 0);
    chk("R1", "aptr", 32'(aptr_o), 0);
    chk("R1", "reqs", 32'({dma_req_o, eob_irq_o, seg_alt_o, to_regfile_o}), 0);

    // Exhaustive sweep: start state x hardware event.
    for (int c = 0; c < 128; c++) begin
      logic p, dm, im, tg, ak, cz, sw, ep, edm;
      logic [2:0] pr;
      p = c[0]; dm = c[1]; im = c[2]; tg = c[3]; ak = c[4]; cz = c[5]; sw = c[6];
      pr = 3'(c * 5);
      write(2'd0, ctrl_word(p, dm, im, pr));
      chk("R7", "ctrl readback", 32'(ctrl_o), 32'(ctrl_word(p, dm, im, pr)));
      chk("R7", "prio", 32'(prio_o), 32'(pr));
      check_routes(p, dm, im, "loaded");
      trig_i = tg; ack_i = ak; cnt_zero_i = cz; swap_i = sw;
      cyc();
      idle();
      ep  = tg ? 1'b1 : (ak ? 1'b0 : p);
      edm = (cz && !sw) ? 1'b0 : dm;
      chk("R2", "pend after event", 32'(ctrl_o[5]), 32'(ep));
      chk("R6", "dm after event", 32'(ctrl_o[4]), 32'(edm));
      check_routes(ep, edm, im, "after event");
    end

    // R3: software write beats trigger and acknowledge.
    write(2'd0, ctrl_word(1, 1, 1, 3'd2));
    wr_en_i = 1; wr_sel_i = 2'd0; wr_data_i = ctrl_word(0, 1, 1, 3'd2); trig_i = 1;
    cyc(); idle();
    chk("R3", "write 0 vs trig", 32'(ctrl_o[5]), 0);
    wr_en_i = 1; wr_sel_i = 2'd0; wr_data_i = ctrl_word(1, 1, 1, 3'd2); ack_i = 1;
    cyc(); idle();
    chk("R3", "write 1 vs ack", 32'(ctrl_o[5]), 1);
    chk("R4", "dma after sw raise", 32'(dma_req_o), 1);
    chk("R4", "irq after sw raise", 32'(eob_irq_o), 1);

    // R6: software write beats self-clear.
    wr_en_i = 1; wr_sel_i = 2'd0; wr_data_i = ctrl_word(0, 1, 0, 3'd7); cnt_zero_i = 1;
    cyc(); idle();
    chk("R6", "write dm vs counter zero", 32'(ctrl_o[4]), 1);

    // R8/R9/R10: pointer registers across values and target settings.
    for (int v = 0; v < 16; v++) begin
      logic [7:0] cv, av;
      cv = 8'((v * 37 + 3) & 8'hFE) | 8'(v[0]);
      av = 8'((v * 91 + 5) & 8'hFE) | 8'(v[1]);
      write(2'd1, cv);
      write(2'd2, av);
      chk("R8", "cptr readback", 32'(cptr_o), 32'(cv));
      chk("R8", "cnt ptr", 32'(cnt_ptr_o), 32'(cv >> 1));
      chk("R8", "target", 32'(to_regfile_o), 32'(cv[0]));
      chk("R9", "addr ptr", 32'(addr_ptr_o), 32'(av >> 1));
      chk("R9", "seg select", 32'(seg_alt_o), 32'(av[0] & ~cv[0]));
      write(2'd3, ~cv);
      chk("R10", "sel 3 cptr", 32'(cptr_o), 32'(cv));
      chk("R10", "sel 3 aptr", 32'(aptr_o), 32'(av));
      chk("R10", "sel 3 ctrl", 32'(ctrl_o), 32'(ctrl_word(0, 1, 0, 3'd7)));
    end
    write(2'd1, 8'h5A);
    chk("R10", "cptr write leaves aptr", 32'(aptr_o[7:1]), 32'(addr_ptr_o));
    chk("R10", "cptr write leaves ctrl", 32'(ctrl_o), 32'(ctrl_word(0, 1, 0, 3'd7)));
    write(2'd0, 8'hFF);
    chk("R7", "upper bits read zero", 32'(ctrl_o), 32'h3F);
    chk("R10", "ctrl write leaves cptr", 32'(cptr_o), 32'h5A);

    // R1: reset again from a loaded state.
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1", "ctrl after reset", 32'(ctrl_o), 0);
    chk("R1", "cptr after reset", 32'(cptr_o), 0);
    chk("R1", "dma after reset", 32'(dma_req_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule